// File: doc/BRIEF.md
# Fuse Array Read Controller

This block lets software fetch one 32-bit word from a one-time-programmable fuse array over a simple 32-bit register bus. Software picks a fuse word address and an optional unlock key in a control register, loads a timing register with a relax count and a read strobe count, and then writes a trigger register. The controller drives the array through a relax phase, a strobe phase and a second relax phase. It then places the fetched word in a read-data register and drops its busy flag.

A failed read sets a sticky error flag and leaves a fixed poison word in the read-data register. A read can fail because the array reports a fault, or because the trigger is refused. The control register also has a set alias and a clear alias, which change selected bits without a read-modify-write. Clearing the error flag is done only through the clear alias. Programming fuses and reloading shadow copies are not part of this block. The program-data register is plain storage.

Top module: `fuse_rd_ctrl`

## Requirements
- R1: After a synchronous active-low reset the control register reads 0 (busy bit 8 and error bit 9 both 0), the read-data register (offset 0x40) reads 0, and the timing register reads the TIMING_RST parameter (default 0x000C1100).
- R2: The timing register at offset 0x10 keeps bits 21:0 and reads zero above them. Its fields are program strobe count in 11:0, relax count in 15:12 and read strobe count in 21:16. The program-data register at 0x20 reads back what was written. The trigger register at 0x30 reads 0.
- R3: A direct write to the control register (0x00) loads the address field (bits 6:0) and the key field (bits 31:16). A write to the set alias (0x04) sets every address or key bit written as 1 and leaves the others unchanged. Busy and error cannot be set through either of these writes.
- R4: A write to the clear alias (0x08) clears every address or key bit written as 1. Writing bit 9 as 1 through this alias clears the error flag.
- R5: Writing bit 0 = 1 to 0x30 starts a read at the control address. A write with bit 0 = 0 does nothing. Busy reads 1 for exactly 2*(relax+1)+S cycles, starting in the cycle after the trigger. The fetched word is in 0x40 when busy first reads 0.
- R6: A read runs as relax+1 cycles with the strobe low, then S cycles with the strobe high, then relax+1 cycles with the strobe low. S is the read strobe count minus 2*(relax+1) when that difference is positive, and 1 otherwise. The fuse address output holds the control address for the whole read.
- R7: If the array reports a fault in the last strobe cycle, the error flag is set and 0x40 returns 0xBADABADA.
- R8: A trigger is refused when busy is set, when the error flag is set, or when the key field is neither 0 nor 0x3E77. A refused trigger sets the error flag and never strobes the array. When the block is idle, a refused trigger also loads 0xBADABADA into 0x40. When busy, the read already running finishes normally.
- R9: The error flag stays set through direct control writes, set-alias writes, clear-alias writes without bit 9, and further triggers.
- R10: While busy, control writes through any of the three addresses leave the address field unchanged. The key field still updates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | BUS_AW | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data (combinational on bus_addr) |
| fuse_strobe | output | 1 | Read strobe to the fuse array |
| fuse_addr | output | FUSE_AW | Fuse word address to the array |
| fuse_data | input | 32 | Word returned by the array |
| fuse_fail | input | 1 | Array fault indication, sampled in the last strobe cycle |

## Verification
The bench builds the block with its default parameters. The field widths are fixed: a 4-bit relax count and a 6-bit read strobe count. This means one test run can reach the extremes of the phase arithmetic, from a zero relax with a one-cycle strobe up to a relax of 15 with a 63-cycle read. It also covers counts too small for the relax phases, which force the minimum one-cycle strobe. Since the longest read is 63 cycles, a trigger can be issued in the middle of a read with cycles to spare. That makes the refusal of a trigger while busy and the freezing of the address field observable at the ports.

// File: rtl/fuse_rd_pkg.sv
// Shared constants and types for the fuse read controller.
// Assumes a byte-addressed register bus with 32-bit registers.
package fuse_rd_pkg;
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_SET   = 8'h04;
    localparam logic [7:0] OFS_CLR   = 8'h08;
    localparam logic [7:0] OFS_TIME  = 8'h10;
    localparam logic [7:0] OFS_PDATA = 8'h20;
    localparam logic [7:0] OFS_TRIG  = 8'h30;
    localparam logic [7:0] OFS_RDATA = 8'h40;

    localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
    localparam logic [31:0] POISON     = 32'hBADA_BADA;

    localparam int ERR_BIT    = 9;
    localparam int KEY_LSB    = 16;
    localparam int RLX_W      = 4;
    localparam int RDS_W      = 6;
    localparam int TM_RLX_LSB = 12;
    localparam int TM_RDS_LSB = 16;
    localparam int TM_W       = TM_RDS_LSB + RDS_W;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_RELAX1,
        PH_STROBE,
        PH_RELAX2
    } phase_e;
endpackage

// File: rtl/fuse_rd_strobe_len.sv
// Computes the strobe-high length of a read from the relax and read strobe
// counts: read count minus both relax phases, never less than one cycle.
// Purely combinational; assumes the field widths from the package.
module fuse_rd_strobe_len
    import fuse_rd_pkg::*;
(
    input  logic [RLX_W-1:0] relax_i,
    input  logic [RDS_W-1:0] rdcnt_i,
    output logic [RDS_W-1:0] len_o
);
    localparam int CW = RDS_W + 2;

    logic [CW-1:0] two_relax;
    logic [CW-1:0] total;

    // Subtract both relax phases from the total, clamping to one cycle.
    always_comb begin
        two_relax = (CW'(relax_i) + CW'(1)) << 1;
        total     = CW'(rdcnt_i);
        if (total > two_relax) begin
            len_o = RDS_W'(total - two_relax);
        end else begin
            len_o = RDS_W'(1);
        end
    end
endmodule

// File: rtl/fuse_rd_seq.sv
// Phase sequencer: on start it latches the address and timing, then runs
// relax, strobe and relax phases and captures the array word and fault at
// the end of the strobe. Assumes start only arrives while idle.
module fuse_rd_seq
    import fuse_rd_pkg::*;
#(
    parameter int FUSE_AW = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [FUSE_AW-1:0] addr_i,
    input  logic [RLX_W-1:0]   relax_i,
    input  logic [RDS_W-1:0]   rdcnt_i,
    input  logic [31:0]        fuse_data_i,
    input  logic               fuse_fail_i,
    output logic               busy_o,
    output logic               fuse_strobe_o,
    output logic [FUSE_AW-1:0] fuse_addr_o,
    output logic               done_o,
    output logic               done_fail_o,
    output logic [31:0]        done_data_o
);
    localparam logic [RDS_W-1:0] ONE = RDS_W'(1);

    phase_e             phase_q;
    logic [RDS_W-1:0]   cnt_q;
    logic [RLX_W-1:0]   relax_q;
    logic [RDS_W-1:0]   slen_q;
    logic [RDS_W-1:0]   slen_w;
    logic [FUSE_AW-1:0] addr_q;
    logic [31:0]        cap_data_q;
    logic               cap_fail_q;

    fuse_rd_strobe_len i_len (
        .relax_i (relax_i),
        .rdcnt_i (rdcnt_i),
        .len_o   (slen_w)
    );

    // Phase state machine with a down-counter per phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_IDLE;
            cnt_q      <= '0;
            relax_q    <= '0;
            slen_q     <= '0;
            addr_q     <= '0;
            cap_data_q <= '0;
            cap_fail_q <= 1'b0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start_i) begin
                        phase_q <= PH_RELAX1;
                        cnt_q   <= RDS_W'(relax_i);
                        relax_q <= relax_i;
                        slen_q  <= slen_w;
                        addr_q  <= addr_i;
                    end
                end
                PH_RELAX1: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_STROBE;
                        cnt_q   <= slen_q - ONE;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                PH_STROBE: begin
                    if (cnt_q == '0) begin
                        phase_q    <= PH_RELAX2;
                        cnt_q      <= RDS_W'(relax_q);
                        cap_data_q <= fuse_data_i;
                        cap_fail_q <= fuse_fail_i;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                PH_RELAX2: begin
                    if (cnt_q == '0) begin
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q - ONE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    // Decode outputs from the phase register.
    always_comb begin
        busy_o        = (phase_q != PH_IDLE);
        fuse_strobe_o = (phase_q == PH_STROBE);
        fuse_addr_o   = addr_q;
        done_o        = (phase_q == PH_RELAX2) && (cnt_q == '0);
        done_fail_o   = cap_fail_q;
        done_data_o   = cap_data_q;
    end

    // R8: the register block never starts a read that is already running.
    p_start_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> phase_q == PH_IDLE);

    // R6: the strobe is always preceded by a first relax phase.
    p_strobe_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fuse_strobe_o) |-> $past(phase_q) == PH_RELAX1);

    // R6: the strobe is always followed by a second relax phase.
    p_strobe_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fuse_strobe_o) |-> phase_q == PH_RELAX2);

    // R6: no strobe phase of zero length is ever entered.
    p_strobe_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_RELAX1 && cnt_q == '0) |-> slen_q != '0);
endmodule

// File: rtl/fuse_rd_regs.sv
// Register file: control register with set and clear aliases, timing,
// program data, trigger and read data. Decides whether a trigger is accepted
// and owns the sticky error flag. Assumes one bus write per cycle.
module fuse_rd_regs
    import fuse_rd_pkg::*;
#(
    parameter int          BUS_AW     = 8,
    parameter int          FUSE_AW    = 7,
    parameter logic [31:0] TIMING_RST = 32'h000C_1100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [BUS_AW-1:0]  addr_i,
    input  logic [31:0]        wdata_i,
    output logic [31:0]        rdata_o,
    input  logic               busy_i,
    input  logic               done_i,
    input  logic               done_fail_i,
    input  logic [31:0]        done_data_i,
    output logic               start_o,
    output logic [FUSE_AW-1:0] faddr_o,
    output logic [RLX_W-1:0]   relax_o,
    output logic [RDS_W-1:0]   rdcnt_o
);
    logic [FUSE_AW-1:0] faddr_q;
    logic [15:0]        key_q;
    logic               err_q;
    logic [TM_W-1:0]    timing_q;
    logic [31:0]        pdata_q;
    logic [31:0]        rdata_q;

    logic wr_ctrl, wr_set, wr_clr, wr_time, wr_pdata;
    logic trig, key_ok, accept, reject, clr_err;
    logic [FUSE_AW-1:0] w_addr;
    logic [15:0]        w_key;

    // Decode bus writes and the trigger decision.
    always_comb begin
        wr_ctrl  = we_i && (addr_i == BUS_AW'(OFS_CTRL));
        wr_set   = we_i && (addr_i == BUS_AW'(OFS_SET));
        wr_clr   = we_i && (addr_i == BUS_AW'(OFS_CLR));
        wr_time  = we_i && (addr_i == BUS_AW'(OFS_TIME));
        wr_pdata = we_i && (addr_i == BUS_AW'(OFS_PDATA));
        trig     = we_i && (addr_i == BUS_AW'(OFS_TRIG)) && wdata_i[0];
        key_ok   = (key_q == 16'h0000) || (key_q == UNLOCK_KEY);
        accept   = trig && !busy_i && !err_q && key_ok;
        reject   = trig && !accept;
        clr_err  = wr_clr && wdata_i[ERR_BIT];
        w_addr   = wdata_i[FUSE_AW-1:0];
        w_key    = wdata_i[KEY_LSB +: 16];
    end

    // Address field: frozen while a read is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            faddr_q <= '0;
        end else if (!busy_i) begin
            if (wr_ctrl)     faddr_q <= w_addr;
            else if (wr_set) faddr_q <= faddr_q | w_addr;
            else if (wr_clr) faddr_q <= faddr_q & ~w_addr;
        end
    end

    // Key field: updated by any of the three control addresses.
    always_ff @(posedge clk) begin
        if (!rst_n)       key_q <= '0;
        else if (wr_ctrl) key_q <= w_key;
        else if (wr_set)  key_q <= key_q | w_key;
        else if (wr_clr)  key_q <= key_q & ~w_key;
    end

    // Sticky error: set by failures, cleared only through the clear alias.
    always_ff @(posedge clk) begin
        if (!rst_n)                           err_q <= 1'b0;
        else if (reject || (done_i && done_fail_i)) err_q <= 1'b1;
        else if (clr_err)                     err_q <= 1'b0;
    end

    // Timing and program-data storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            timing_q <= TIMING_RST[TM_W-1:0];
            pdata_q  <= '0;
        end else begin
            if (wr_time)  timing_q <= wdata_i[TM_W-1:0];
            if (wr_pdata) pdata_q  <= wdata_i;
        end
    end

    // Read data: array word or poison on completion, poison on idle refusal.
    always_ff @(posedge clk) begin
        if (!rst_n)                 rdata_q <= '0;
        else if (done_i)            rdata_q <= done_fail_i ? POISON : done_data_i;
        else if (reject && !busy_i) rdata_q <= POISON;
    end

    // Register read mux and sequencer-facing outputs.
    always_comb begin
        case (addr_i)
            BUS_AW'(OFS_CTRL), BUS_AW'(OFS_SET), BUS_AW'(OFS_CLR):
                rdata_o = {key_q, 6'd0, err_q, busy_i, 1'b0, 7'(faddr_q)};
            BUS_AW'(OFS_TIME):  rdata_o = 32'(timing_q);
            BUS_AW'(OFS_PDATA): rdata_o = pdata_q;
            BUS_AW'(OFS_RDATA): rdata_o = rdata_q;
            default:            rdata_o = '0;
        endcase
        start_o = accept;
        faddr_o = faddr_q;
        relax_o = timing_q[TM_RLX_LSB +: RLX_W];
        rdcnt_o = timing_q[TM_RDS_LSB +: RDS_W];
    end

    // R7: an array fault leaves poison and the error flag.
    p_fail_poison_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && done_fail_i) |=> (rdata_q == POISON) && err_q);

    // R9: the error flag only drops through the clear alias bit.
    p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_err) |=> err_q);

    // R10: the address field holds while busy.
    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && $past(busy_i)) |-> $stable(faddr_q));
endmodule

// File: rtl/fuse_rd_ctrl.sv
// Top of the fuse read controller: joins the register file to the phase
// sequencer and exposes the register bus and the fuse array pins.
// Assumes the array presents data and fault combinationally from the address.
module fuse_rd_ctrl
    import fuse_rd_pkg::*;
#(
    parameter int          BUS_AW     = 8,
    parameter int          FUSE_AW    = 7,
    parameter logic [31:0] TIMING_RST = 32'h000C_1100
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [BUS_AW-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               fuse_strobe,
    output logic [FUSE_AW-1:0] fuse_addr,
    input  logic [31:0]        fuse_data,
    input  logic               fuse_fail
);
    logic               busy;
    logic               start;
    logic               done;
    logic               done_fail;
    logic [31:0]        done_data;
    logic [FUSE_AW-1:0] faddr;
    logic [RLX_W-1:0]   relax;
    logic [RDS_W-1:0]   rdcnt;

    fuse_rd_regs #(
        .BUS_AW     (BUS_AW),
        .FUSE_AW    (FUSE_AW),
        .TIMING_RST (TIMING_RST)
    ) i_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (bus_we),
        .addr_i      (bus_addr),
        .wdata_i     (bus_wdata),
        .rdata_o     (bus_rdata),
        .busy_i      (busy),
        .done_i      (done),
        .done_fail_i (done_fail),
        .done_data_i (done_data),
        .start_o     (start),
        .faddr_o     (faddr),
        .relax_o     (relax),
        .rdcnt_o     (rdcnt)
    );

    fuse_rd_seq #(
        .FUSE_AW (FUSE_AW)
    ) i_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .start_i       (start),
        .addr_i        (faddr),
        .relax_i       (relax),
        .rdcnt_i       (rdcnt),
        .fuse_data_i   (fuse_data),
        .fuse_fail_i   (fuse_fail),
        .busy_o        (busy),
        .fuse_strobe_o (fuse_strobe),
        .fuse_addr_o   (fuse_addr),
        .done_o        (done),
        .done_fail_o   (done_fail),
        .done_data_o   (done_data)
    );

    // R6: the array is strobed only inside a busy read.
    p_strobe_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fuse_strobe |-> busy);
endmodule

// File: tb/test_fuse_rd_ctrl.sv
`timescale 1ns/1ps
module test_fuse_rd_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic [31:0] bus_rdata;
    logic        fuse_strobe;
    logic [6:0]  fuse_addr;
    logic [31:0] fuse_data;
    logic        fuse_fail = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    int strobe_cnt = 0;
    logic [6:0] strobe_addr = 7'h0;

    always #2.5 clk = ~clk;

    function automatic logic [31:0] fmodel(input logic [6:0] a);
        return {8'hC3, 1'b0, a, 8'h5A, 1'b1, a};
    endfunction

    assign fuse_data = fmodel(fuse_addr);

    fuse_rd_ctrl #(.BUS_AW(8), .FUSE_AW(7), .TIMING_RST(32'h000C_1100)) i_fuse_rd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fuse_strobe(fuse_strobe),
        .fuse_addr(fuse_addr), .fuse_data(fuse_data), .fuse_fail(fuse_fail)
    );

    always @(negedge clk) begin
        if (fuse_strobe) begin
            strobe_cnt++;
            strobe_addr = fuse_addr;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_idle(output int n);
        logic [31:0] v;
        n = 0;
        rd(8'h00, v);
        while (v[8]) begin
            n++;
            @(negedge clk);
            rd(8'h00, v);
        end
    endtask

    task automatic run_read(input logic [3:0] rlx, input logic [5:0] rds, input logic [6:0] a,
                            input logic fail, input logic [15:0] key);
        int n, s0, two, exp_s;
        logic [31:0] v;
        wr(8'h10, {10'd0, rds, rlx, 12'h0AB});
        wr(8'h00, {key, 9'd0, a});
        fuse_fail = fail;
        s0 = strobe_cnt;
        wr(8'h30, 32'h1);
        wait_idle(n);
        two = 2 * (int'(rlx) + 1);
        exp_s = (int'(rds) > two) ? int'(rds) - two : 1;
        check("R5 busy cycles", n, two + exp_s);
        check("R6 strobe cycles", strobe_cnt - s0, exp_s);
        check("R6 fuse address", strobe_addr, a);
        rd(8'h40, v);
        check(fail ? "R7 poison data" : "R5 read data", v, fail ? 32'hBADA_BADA : fmodel(a));
        rd(8'h00, v);
        check(fail ? "R7 error set" : "R5 no error", v[9], fail);
        fuse_fail = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h00, v); check("R1 control reset", v, 32'h0);
        rd(8'h40, v); check("R1 read data reset", v, 32'h0);
        rd(8'h10, v); check("R1 timing reset", v, 32'h000C_1100);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        int s0 = strobe_cnt;
        wr(8'h10, 32'hFFFF_FABC); rd(8'h10, v); check("R2 timing width", v, 32'h003F_FABC);
        wr(8'h20, 32'h1234_5678); rd(8'h20, v); check("R2 program data", v, 32'h1234_5678);
        rd(8'h30, v); check("R2 trigger reads zero", v, 32'h0);
        check("R2 no strobe from data write", strobe_cnt - s0, 0);
    endtask

    task automatic t_alias();
        logic [31:0] v;
        wr(8'h00, 32'h0000_0005);
        wr(8'h04, 32'h3E00_0042); rd(8'h00, v); check("R3 set alias", v, 32'h3E00_0047);
        wr(8'h04, 32'h0);         rd(8'h00, v); check("R3 set zero no change", v, 32'h3E00_0047);
        wr(8'h04, 32'h0000_0300); rd(8'h00, v); check("R3 status not settable", v, 32'h3E00_0047);
        wr(8'h08, 32'h0000_0003); rd(8'h00, v); check("R4 clear alias addr", v, 32'h3E00_0044);
        wr(8'h08, 32'hFFFF_0000); rd(8'h00, v); check("R4 clear alias key", v, 32'h0000_0044);
    endtask

    task automatic t_reads();
        logic [31:0] v;
        int s0;
        run_read(4'd1, 6'd12, 7'h05, 1'b0, 16'h3E77);
        run_read(4'd0, 6'd3, 7'h7F, 1'b0, 16'h3E77);
        run_read(4'd3, 6'd4, 7'h21, 1'b0, 16'h3E77);
        run_read(4'd15, 6'd63, 7'h3A, 1'b0, 16'h0000);
        s0 = strobe_cnt;
        wr(8'h30, 32'h2);
        rd(8'h00, v); check("R5 bit0 clear no busy", v[8], 1'b0);
        @(negedge clk); @(negedge clk);
        check("R5 bit0 clear no strobe", strobe_cnt - s0, 0);
    endtask

    task automatic t_fail();
        logic [31:0] v;
        int s0;
        run_read(4'd1, 6'd10, 7'h0F, 1'b1, 16'h3E77);
        wr(8'h00, 32'h3E77_000F); rd(8'h00, v); check("R9 direct write keeps error", v[9], 1'b1);
        wr(8'h04, 32'h0);         rd(8'h00, v); check("R9 set alias keeps error", v[9], 1'b1);
        wr(8'h08, 32'h0000_0001); rd(8'h00, v); check("R9 clear without bit9 keeps error", v[9], 1'b1);
        s0 = strobe_cnt;
        wr(8'h30, 32'h1);
        wait_idle(s0 == s0 ? v[0] : v[0]);
        check("R9 trigger refused while error", strobe_cnt - s0, 0);
        rd(8'h40, v); check("R9 poison after refused trigger", v, 32'hBADA_BADA);
        wr(8'h08, 32'h0000_0200); rd(8'h00, v); check("R4 clear alias clears error", v[9], 1'b0);
    endtask

    task automatic t_badkey();
        logic [31:0] v;
        int s0;
        run_read(4'd1, 6'd12, 7'h05, 1'b0, 16'h3E77);
        wr(8'h00, 32'h1234_0005);
        s0 = strobe_cnt;
        wr(8'h30, 32'h1);
        rd(8'h00, v); check("R8 bad key not busy", v[8], 1'b0);
        check("R8 bad key error", v[9], 1'b1);
        @(negedge clk); @(negedge clk);
        check("R8 bad key no strobe", strobe_cnt - s0, 0);
        rd(8'h40, v); check("R8 bad key poison", v, 32'hBADA_BADA);
        wr(8'h08, 32'h0000_0200);
        run_read(4'd0, 6'd6, 7'h06, 1'b0, 16'h0000);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        int s0, n;
        wr(8'h10, {10'd0, 6'd40, 4'd1, 12'h0});
        wr(8'h00, 32'h3E77_0011);
        s0 = strobe_cnt;
        wr(8'h30, 32'h1);
        @(negedge clk); @(negedge clk);
        wr(8'h00, 32'h0000_0022);
        rd(8'h00, v); check("R10 direct write while busy", v, 32'h0000_0111);
        wr(8'h04, 32'h0000_0004);
        rd(8'h00, v); check("R10 set alias while busy", v[6:0], 7'h11);
        wr(8'h30, 32'h1);
        rd(8'h00, v); check("R8 trigger while busy sets error", v[9], 1'b1);
        wait_idle(n);
        check("R8 running read completes once", strobe_cnt - s0, 36);
        rd(8'h40, v); check("R8 running read data kept", v, fmodel(7'h11));
        wr(8'h08, 32'h0000_0200);
    endtask

    initial begin
        #750000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_alias();
        t_reads();
        t_fail();
        t_badkey();
        t_busy();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule